// File: doc/BRIEF.md
# Serial Configuration Loader for a Waveform Sampling Chip

This block runs inside an FPGA and programs two 8-bit registers of a switched-capacitor sampling chip through a serial interface. The chip has a 4-bit address bus, a serial data line and a serial clock. A single host write strobe carries two bytes: a configuration byte and a write-shift pattern, for example 8'h55 for cascaded four-channel sampling. The block loads both bytes in a fixed order. Each load has a setup phase and a strobe phase.

The sampling wave inside the chip runs in a circle and can move the write-shift register while the chip's write-enable line is high. For that reason the loader holds write-enable low from the cycle after it accepts a write until the sequence ends. It passes the sampling enable through untouched, so the wave keeps running during the load. When the sequence ends, write-enable goes back to the level it had when the write was accepted. After that it follows its idle input again.

The serial clock half-period is programmable in system clocks, with a floor of two, so one serial clock period is never shorter than four system clocks. The host sees a busy level and a one-cycle done pulse. A write that arrives while the block is busy is dropped and raises an error flag.

Top module: `cfg_loader_top`

## Requirements
- R1: One accepted write produces exactly 16 rising edges of `chip_sclk`: 8 for the configuration byte, then 8 for the write-shift byte.
- R2: At every rising edge of `chip_sclk`, `chip_addr` is 4'b1100 during the configuration load and 4'b1101 during the write-shift load. Outside a load it is 4'b0000.
- R3: Bits are sent MSB first. `chip_sdi` changes only while `chip_sclk` is low, and it has the same value in the cycle before each rising edge as at that edge.
- R4: `chip_wr` is 0 in every cycle while `busy` is 1. In the first cycle after `busy` falls, `chip_wr` equals the `wr_lvl` value sampled when the write was accepted.
- R5: `chip_en` equals `sample_en` delayed by one clock. A load does not change this.
- R6: The high and low phases of `chip_sclk` each last H = max(`sck_half`, 2) system clocks. `busy` stays high for exactly 35·H cycles.
- R7: `busy` rises in the cycle after the accepting edge. `done` pulses high for one cycle, in the first cycle in which `busy` is low again.
- R8: A write strobe that arrives while `busy` is 1 has no effect on the bytes sent. It sets `err`, which stays set until the next accepted write clears it.
- R9: While idle, `chip_wr` follows `wr_lvl` with a one-cycle delay. Right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe from the host, one cycle |
| host_cfg | input | 8 | Configuration byte |
| host_wsr | input | 8 | Write-shift pattern byte |
| sck_half | input | 8 | Serial clock half-period in system clocks (values below 2 act as 2) |
| wr_lvl | input | 1 | Write-enable level to drive when not loading |
| sample_en | input | 1 | Sampling enable request |
| chip_addr | output | 4 | Chip register address |
| chip_sclk | output | 1 | Serial clock to the chip |
| chip_sdi | output | 1 | Serial data to the chip |
| chip_wr | output | 1 | Chip write-enable |
| chip_en | output | 1 | Chip sampling enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Sticky flag for a write dropped while busy |

## Verification
The in-line assertions check, on every cycle, the relations between outputs:
- write-enable is low whenever a chip register address is driven;
- serial data holds still while the serial clock is high;
- serial clock edges occur only while busy;
- done comes only as busy ends;
- a collision sets the error flag.

Other properties need the bench's scenarios to show them. These are the exact bytes received MSB first, the count of sixteen edges, the phase lengths, the total busy length for each divider setting, and the restored write-enable level after the live input has changed mid-load. The bench therefore sweeps several divider values and data patterns, with and without collisions.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_CFG_SETUP  = 3'd1,
        ST_CFG_STROBE = 3'd2,
        ST_WSR_SETUP  = 3'd3,
        ST_WSR_STROBE = 3'd4,
        ST_RESTORE    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/cfg_loader_timer.sv
module cfg_loader_timer #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [DIV_W-1:0] half_cfg,
    output logic             expire
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] half_eff;

    always_comb begin
        half_eff = (half_cfg < MIN_V) ? MIN_V : half_cfg;
        cnt_d    = cnt_q;
        if (reload) begin
            cnt_d = half_eff - DIV_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/cfg_loader_shreg.sv
module cfg_loader_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)       sh_d = load_val;
        else if (shift) sh_d = {sh_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb = sh_q[W-1];

endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top
    import cfg_loader_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter int              ADDR_W    = 4,
    parameter int              DIV_W     = 8,
    parameter int              MIN_HALF  = 2,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 4'b1100,
    parameter logic [ADDR_W-1:0] WSR_ADDR  = 4'b1101,
    parameter logic [ADDR_W-1:0] IDLE_ADDR = 4'b0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_cfg,
    input  logic [DATA_W-1:0] host_wsr,
    input  logic [DIV_W-1:0]  sck_half,
    input  logic              wr_lvl,
    input  logic              sample_en,
    output logic [ADDR_W-1:0] chip_addr,
    output logic              chip_sclk,
    output logic              chip_sdi,
    output logic              chip_wr,
    output logic              chip_en,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        seq_state_t        st;
        logic              hi;
        logic [BIT_W-1:0]  bit_n;
        logic [ADDR_W-1:0] addr;
        logic              sclk;
        logic              wr;
        logic              saved;
        logic              en;
        logic              busy;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] wsr_hold;
    } regs_t;

    localparam regs_t RESET_R = '{
        st: ST_IDLE, hi: 1'b0, bit_n: '0, addr: IDLE_ADDR, sclk: 1'b0,
        wr: 1'b0, saved: 1'b0, en: 1'b0, busy: 1'b0, done: 1'b0,
        err: 1'b0, wsr_hold: '0
    };

    regs_t r_d, r_q;

    logic              tmr_reload;
    logic              tmr_expire;
    logic              sh_load;
    logic [DATA_W-1:0] sh_val;
    logic              sh_shift;
    logic              sdi_w;

    cfg_loader_timer #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (tmr_reload),
        .half_cfg (sck_half),
        .expire   (tmr_expire)
    );

    cfg_loader_shreg #(
        .W (DATA_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .msb      (sdi_w)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.en     = sample_en;
        tmr_reload = 1'b0;
        sh_load    = 1'b0;
        sh_val     = host_cfg;
        sh_shift   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.wr   = wr_lvl;
                r_d.addr = IDLE_ADDR;
                r_d.sclk = 1'b0;
                if (host_wr) begin
                    r_d.st       = ST_CFG_SETUP;
                    r_d.busy     = 1'b1;
                    r_d.wr       = 1'b0;
                    r_d.saved    = wr_lvl;
                    r_d.addr     = CFG_ADDR;
                    r_d.err      = 1'b0;
                    r_d.wsr_hold = host_wsr;
                    sh_load      = 1'b1;
                    sh_val       = host_cfg;
                    tmr_reload   = 1'b1;
                end
            end
            ST_CFG_SETUP, ST_WSR_SETUP: begin
                if (tmr_expire) begin
                    r_d.st     = (r_q.st == ST_CFG_SETUP) ? ST_CFG_STROBE : ST_WSR_STROBE;
                    r_d.sclk   = 1'b1;
                    r_d.hi     = 1'b1;
                    r_d.bit_n  = '0;
                    tmr_reload = 1'b1;
                end
            end
            ST_CFG_STROBE, ST_WSR_STROBE: begin
                if (tmr_expire) begin
                    tmr_reload = 1'b1;
                    if (r_q.hi) begin
                        r_d.sclk = 1'b0;
                        r_d.hi   = 1'b0;
                        if (r_q.bit_n != LAST_BIT) sh_shift = 1'b1;
                    end else if (r_q.bit_n == LAST_BIT) begin
                        if (r_q.st == ST_CFG_STROBE) begin
                            r_d.st   = ST_WSR_SETUP;
                            r_d.addr = WSR_ADDR;
                            sh_load  = 1'b1;
                            sh_val   = r_q.wsr_hold;
                        end else begin
                            r_d.st   = ST_RESTORE;
                            r_d.addr = IDLE_ADDR;
                        end
                    end else begin
                        r_d.bit_n = r_q.bit_n + BIT_W'(1);
                        r_d.sclk  = 1'b1;
                        r_d.hi    = 1'b1;
                    end
                end
            end
            ST_RESTORE: begin
                if (tmr_expire) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                    r_d.wr   = r_q.saved;
                end
            end
            default: r_d = RESET_R;
        endcase

        if (r_q.busy && host_wr) r_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RESET_R;
        else        r_q <= r_d;
    end

    assign chip_addr = r_q.addr;
    assign chip_sclk = r_q.sclk;
    assign chip_sdi  = sdi_w;
    assign chip_wr   = r_q.wr;
    assign chip_en   = r_q.en;
    assign busy      = r_q.busy;
    assign done      = r_q.done;
    assign err       = r_q.err;

    AST_WR_LOW_ON_REG_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_addr == CFG_ADDR || chip_addr == WSR_ADDR) |-> !chip_wr); // R4
    AST_SDI_HELD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sclk && $past(chip_sclk)) |-> $stable(chip_sdi)); // R3
    AST_EDGE_AT_REG_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_sclk) |-> (chip_addr == CFG_ADDR || chip_addr == WSR_ADDR)); // R2
    AST_SCLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sclk |-> busy); // R1
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7
    AST_COLLISION_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr) |=> err); // R8

endmodule

// File: tb/sim_cfg_loader_top.sv
`timescale 1ns/1ps
module sim_cfg_loader_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_cfg = '0;
    logic [7:0] host_wsr = '0;
    logic [7:0] sck_half = 8'd2;
    logic       wr_lvl = 1'b0;
    logic       sample_en = 1'b0;
    logic [3:0] chip_addr;
    logic       chip_sclk, chip_sdi, chip_wr, chip_en, busy, done, err;

    always #10 clk = ~clk;

    cfg_loader_top u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_cfg(host_cfg),
        .host_wsr(host_wsr), .sck_half(sck_half), .wr_lvl(wr_lvl),
        .sample_en(sample_en), .chip_addr(chip_addr), .chip_sclk(chip_sclk),
        .chip_sdi(chip_sdi), .chip_wr(chip_wr), .chip_en(chip_en),
        .busy(busy), .done(done), .err(err)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // monitor state
    int   exp_h = 2;
    int   busy_cnt, cfg_n, wsr_n, addr_bad, sdi_bad, hi_bad, hi_run;
    int   wr_bad, en_bad, done_n, done_bad, first_addr;
    logic [7:0] cfg_got, wsr_got;
    logic sclk_prev = 0, sdi_prev = 0;

    task automatic clear_mon();
        busy_cnt = 0; cfg_n = 0; wsr_n = 0; addr_bad = 0; sdi_bad = 0;
        hi_bad = 0; hi_run = 0; wr_bad = 0; en_bad = 0; done_n = 0;
        done_bad = 0; first_addr = -1; cfg_got = '0; wsr_got = '0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (busy && chip_wr) wr_bad++;
            if (chip_en !== sample_en) en_bad++;
            if (chip_sclk && !sclk_prev) begin
                if (chip_sdi !== sdi_prev) sdi_bad++;
                if (first_addr < 0) first_addr = int'(chip_addr);
                if (chip_addr == 4'b1100) begin
                    cfg_got = {cfg_got[6:0], chip_sdi}; cfg_n++;
                end else if (chip_addr == 4'b1101) begin
                    wsr_got = {wsr_got[6:0], chip_sdi}; wsr_n++;
                end else addr_bad++;
            end
            if (chip_sclk && sclk_prev && chip_sdi !== sdi_prev) sdi_bad++;
            if (chip_sclk) hi_run++;
            else begin
                if (sclk_prev && hi_run != exp_h) hi_bad++;
                hi_run = 0;
            end
            if (done) begin
                done_n++;
                if (busy) done_bad++;
            end
            sclk_prev = chip_sclk;
            sdi_prev  = chip_sdi;
        end
    end

    task automatic run_one(input logic [7:0] c, input logic [7:0] w, input int div,
                           input bit lvl, input bit en, input bit collide);
        int h;
        h = (div < 2) ? 2 : div;
        @(negedge clk);
        sck_half = 8'(div); wr_lvl = lvl; sample_en = en;
        @(negedge clk);
        @(negedge clk);
        exp_h = h;
        clear_mon();
        chk(chip_wr == lvl, "R9 idle write-enable follows level", int'(chip_wr), int'(lvl));
        host_cfg = c; host_wsr = w; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        host_cfg = ~c; host_wsr = ~w;
        chk(busy == 1'b1, "R7 busy one cycle after accept", int'(busy), 1);
        chk(chip_wr == 1'b0, "R4 write-enable dropped at start", int'(chip_wr), 0);
        wr_lvl = ~lvl;
        if (collide) begin
            repeat (5) @(negedge clk);
            host_wr = 1'b1;
            @(negedge clk);
            host_wr = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(chip_wr == lvl, "R4 write-enable restored to captured level", int'(chip_wr), int'(lvl));
        chk(done == 1'b1, "R7 done as busy falls", int'(done), 1);
        chk(chip_addr == 4'b0000, "R2 idle address", int'(chip_addr), 0);
        @(negedge clk);
        chk(chip_wr == ~lvl, "R9 write-enable follows live level after restore", int'(chip_wr), int'(~lvl));
        chk(done == 1'b0, "R7 done lasts one cycle", int'(done), 0);
        chk(cfg_n == 8, "R1 config edges", cfg_n, 8);
        chk(wsr_n == 8, "R1 write-shift edges", wsr_n, 8);
        chk(first_addr == 12, "R1 config load first", first_addr, 12);
        chk(cfg_got == c, "R3 config byte MSB first", int'(cfg_got), int'(c));
        chk(wsr_got == w, "R3 write-shift byte MSB first", int'(wsr_got), int'(w));
        chk(sdi_bad == 0, "R3 data stable around clock high", sdi_bad, 0);
        chk(addr_bad == 0, "R2 address at each edge", addr_bad, 0);
        chk(wr_bad == 0, "R4 write-enable low while busy", wr_bad, 0);
        chk(en_bad == 0, "R5 sampling enable untouched", en_bad, 0);
        chk(hi_bad == 0, "R6 high phase length", hi_bad, 0);
        chk(busy_cnt == 35 * h, "R6 busy length", busy_cnt, 35 * h);
        chk(done_n == 1 && done_bad == 0, "R7 single done pulse", done_n, 1);
        chk(err == collide, "R8 error flag", int'(err), int'(collide));
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] cfgs [4];
        logic [7:0] wsrs [4];
        int divs [6];
        cfgs = '{8'hA5, 8'h00, 8'h80, 8'h3C};
        wsrs = '{8'h55, 8'hFF, 8'h01, 8'hC3};
        divs = '{0, 1, 2, 3, 4, 6};
        repeat (3) @(negedge clk);
        // R9 reset state
        chk({chip_addr, chip_sclk, chip_sdi, chip_wr, chip_en, busy, done, err} == '0,
            "R9 reset outputs", int'({chip_addr, chip_sclk, chip_sdi, chip_wr, chip_en, busy, done, err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int d = 0; d < 6; d++) begin
            for (int p = 0; p < 4; p++) begin
                run_one(cfgs[p], wsrs[p], divs[d], bit'((d + p) % 2), bit'(p != 1), bit'(p == 2));
            end
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule